// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block keeps, for every interrupt source of a chip, whether the source is enabled, whether it is pending, how it is sensed (edge or level), and, for the shared sources, whether its input line is active-low. Software reaches all of this state through a simple 32-bit word-addressed read/write bus. Raw interrupt lines first pass through the polarity stage. Each corrected line is then sensed as a level or as a rising edge, and the result sets the source's pending flag.

Downstream logic sees a registered vector holding one request bit per source. A bit is high when its source is both enabled and pending. After taking a source, the consumer clears its pending flag with an acknowledge pulse that carries the source number. Priority arbitration and delivery to processors happen outside this block. Sources 0 to 15 are software-generated, so their sensing mode is fixed. Sources 16 to 31 are private. Sources 32 and up are shared, and only they can be inverted.

The bus address splits into a region in the top 4 bits and a word index in the low 4 bits.

Top module: `irq_pend_bank`

## Requirements
- R1: After reset, enable bits of sources 0..15 are 1 and all other enables are 0, no source is pending, every polarity bit is 0, sources 16 and up are level-sensed, and req_vec is 0.
- R2: Region 0 is the enable-set alias. Word w covers sources 32w..32w+31, and source s sits at bit s mod 32. Writing a 1 sets that enable, writing 0 changes nothing, and a read returns the current enables.
- R3: Region 1 is the enable-clear alias. Writing a 1 clears that enable, writing 0 changes nothing, and a read returns the current enables.
- R4: Region 4 holds the sensing mode with 2 bits per source, 16 sources per word. Source 16w+i uses bits 2i+1 (1 = edge, 0 = level) and 2i. The lower bit of each pair reads 0 and ignores writes.
- R5: The mode of sources 0..15 is fixed at edge, so config word 0 always reads 0xAAAAAAAA and writes to it are ignored.
- R6: Region 5 holds polarity. Word w bit b controls source 32+32w+b, and a 1 inverts the line before sensing (active-low). Sources below 32 are never inverted.
- R7: An edge-mode source becomes pending when its corrected line goes from 0 to 1. A line held high does not set it again after the flag has been cleared.
- R8: A level-mode source is set pending in every cycle its corrected line is 1, so a clear has no lasting effect while the line stays high.
- R9: Region 2 is the pending-set alias and region 3 the pending-clear alias, with the same packing as R2. Writing a 1 sets (or clears) that flag, and reads of either alias return the pending flags.
- R10: An ack_valid pulse clears the pending flag of source ack_id. If a set occurs for the same source in the same cycle, the set wins.
- R11: req_vec is registered: each bit equals enable AND pending of that source as they stood one clock earlier.
- R12: bus_rdata updates on the clock edge where bus_rd is high and is valid from the next cycle. Unmapped regions, and word indices beyond the implemented sources, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Word address: region in [7:4], index in [3:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 128 | Raw interrupt lines, one per source |
| ack_valid | input | 1 | Acknowledge pulse |
| ack_id | input | 7 | Source cleared by the acknowledge |
| req_vec | output | 128 | Enabled-and-pending request per source |

## Verification
The assertions assume that irq_in and the bus signals are synchronous to clk. The bench meets this by changing every input on the falling edge only. The assertions also assume that at most one bus access is made per cycle, and that ack_id names an implemented source. The bench drives a single strobe at a time through its write and read tasks, and acknowledges only sources below 128. The level-sensing property compares each cycle's corrected lines with the next cycle's pending flags, so the bench holds each line for whole cycles rather than glitching it between edges.

// File: rtl/irq_pend_bank_pkg.sv
package irq_pend_bank_pkg;
  localparam int RGN_W       = 4;
  localparam int SGI_COUNT   = 16;
  localparam int SHARED_BASE = 32;

  typedef enum logic [RGN_W-1:0] {
    RG_EN_SET = 4'd0,
    RG_EN_CLR = 4'd1,
    RG_PD_SET = 4'd2,
    RG_PD_CLR = 4'd3,
    RG_CFG    = 4'd4,
    RG_POL    = 4'd5
  } region_e;
endpackage

// File: rtl/irq_pend_bank_sense.sv
module irq_pend_bank_sense #(
  parameter int NUM_SRC = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] pol_vec,
  input  logic [NUM_SRC-1:0] cfg_edge,
  output logic [NUM_SRC-1:0] hw_set
);
  logic [NUM_SRC-1:0] line_q;

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic corr;
      assign corr      = irq_in[s] ^ pol_vec[s];
      assign hw_set[s] = cfg_edge[s] ? (corr & ~line_q[s]) : corr;
      always_ff @(posedge clk) begin
        if (rst) line_q[s] <= 1'b0;
        else     line_q[s] <= corr;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_pend_bank_regs.sv
module irq_pend_bank_regs
  import irq_pend_bank_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] hw_set,
  input  logic               ack_valid,
  input  logic [SRC_W-1:0]   ack_id,
  output logic [NUM_SRC-1:0] en_vec,
  output logic [NUM_SRC-1:0] pend_vec,
  output logic [NUM_SRC-1:0] cfg_edge,
  output logic [NUM_SRC-1:0] pol_vec
);
  localparam int IDX_W  = ADDR_W - RGN_W;
  localparam int NW     = NUM_SRC / DATA_W;
  localparam int PER_CW = DATA_W / 2;
  localparam int NCW    = NUM_SRC / PER_CW;
  localparam int NPW    = (NUM_SRC - SHARED_BASE) / DATA_W;
  localparam logic [NUM_SRC-1:0] SGI_MASK = {{(NUM_SRC-SGI_COUNT){1'b0}}, {SGI_COUNT{1'b1}}};
  localparam logic [NUM_SRC-1:0] LOW_MASK = {{(NUM_SRC-SHARED_BASE){1'b0}}, {SHARED_BASE{1'b1}}};

  region_e            rgn;
  logic [IDX_W-1:0]   idx;
  logic [NUM_SRC-1:0] en_q, pend_q, cfg_q, pol_q;
  logic [NUM_SRC-1:0] en_d, pend_d, cfg_d, pol_d;
  logic [DATA_W-1:0]  rd_d;

  assign rgn = region_e'(bus_addr[ADDR_W-1 -: RGN_W]);
  assign idx = bus_addr[IDX_W-1:0];

  // next-state: clears first, then sets so that a set wins (R10)
  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    cfg_d  = cfg_q;
    pol_d  = pol_q;
    if (bus_wr) begin
      for (int w = 0; w < NW; w++) begin
        if (idx == IDX_W'(w)) begin
          case (rgn)
            RG_EN_SET: en_d[w*DATA_W +: DATA_W]   = en_q[w*DATA_W +: DATA_W] | bus_wdata;
            RG_EN_CLR: en_d[w*DATA_W +: DATA_W]   = en_q[w*DATA_W +: DATA_W] & ~bus_wdata;
            RG_PD_CLR: pend_d[w*DATA_W +: DATA_W] = pend_q[w*DATA_W +: DATA_W] & ~bus_wdata;
            default: ;
          endcase
        end
      end
    end
    if (ack_valid) pend_d[ack_id] = 1'b0;
    pend_d = pend_d | hw_set;
    if (bus_wr && rgn == RG_PD_SET) begin
      for (int w = 0; w < NW; w++)
        if (idx == IDX_W'(w))
          pend_d[w*DATA_W +: DATA_W] = pend_d[w*DATA_W +: DATA_W] | bus_wdata;
    end
    if (bus_wr && rgn == RG_CFG) begin
      for (int w = 0; w < NCW; w++)
        if (idx == IDX_W'(w))
          for (int i = 0; i < PER_CW; i++)
            cfg_d[w*PER_CW + i] = bus_wdata[2*i+1];
    end
    cfg_d = cfg_d | SGI_MASK;
    if (bus_wr && rgn == RG_POL) begin
      for (int w = 0; w < NPW; w++)
        if (idx == IDX_W'(w))
          pol_d[SHARED_BASE + w*DATA_W +: DATA_W] = bus_wdata;
    end
    pol_d = pol_d & ~LOW_MASK;
  end

  always_comb begin
    rd_d = '0;
    case (rgn)
      RG_EN_SET, RG_EN_CLR:
        for (int w = 0; w < NW; w++)
          if (idx == IDX_W'(w)) rd_d = en_q[w*DATA_W +: DATA_W];
      RG_PD_SET, RG_PD_CLR:
        for (int w = 0; w < NW; w++)
          if (idx == IDX_W'(w)) rd_d = pend_q[w*DATA_W +: DATA_W];
      RG_CFG:
        for (int w = 0; w < NCW; w++)
          if (idx == IDX_W'(w))
            for (int i = 0; i < PER_CW; i++) rd_d[2*i+1] = cfg_q[w*PER_CW + i];
      RG_POL:
        for (int w = 0; w < NPW; w++)
          if (idx == IDX_W'(w)) rd_d = pol_q[SHARED_BASE + w*DATA_W +: DATA_W];
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= SGI_MASK;
      pend_q    <= '0;
      cfg_q     <= SGI_MASK;
      pol_q     <= '0;
      bus_rdata <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      cfg_q  <= cfg_d;
      pol_q  <= pol_d;
      if (bus_rd) bus_rdata <= rd_d;
    end
  end

  assign en_vec   = en_q;
  assign pend_vec = pend_q;
  assign cfg_edge = cfg_q;
  assign pol_vec  = pol_q;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 128,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               ack_valid,
  input  logic [SRC_W-1:0]   ack_id,
  output logic [NUM_SRC-1:0] req_vec
);
  logic [NUM_SRC-1:0] en_vec, pend_vec, cfg_edge, pol_vec, hw_set;

  irq_pend_bank_sense #(.NUM_SRC(NUM_SRC)) u_sense (
    .clk(clk), .rst(rst), .irq_in(irq_in), .pol_vec(pol_vec),
    .cfg_edge(cfg_edge), .hw_set(hw_set)
  );

  irq_pend_bank_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_set(hw_set),
    .ack_valid(ack_valid), .ack_id(ack_id), .en_vec(en_vec), .pend_vec(pend_vec),
    .cfg_edge(cfg_edge), .pol_vec(pol_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) req_vec <= '0;
    else     req_vec <= en_vec & pend_vec;
  end
endmodule

// File: rtl/irq_pend_bank_chk.sv
module irq_pend_bank_chk
  import irq_pend_bank_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [NUM_SRC-1:0] irq_in,
  input logic [NUM_SRC-1:0] req_vec,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [NUM_SRC-1:0] pend_vec,
  input logic [NUM_SRC-1:0] cfg_edge,
  input logic [NUM_SRC-1:0] pol_vec
);
  localparam logic [ADDR_W-1:0] EN_SET_W0 = ADDR_W'(RG_EN_SET) << (ADDR_W - RGN_W);
  localparam logic [ADDR_W-1:0] EN_CLR_W0 = ADDR_W'(RG_EN_CLR) << (ADDR_W - RGN_W);
  localparam logic [NUM_SRC-1:0] RST_EN = {{(NUM_SRC-SGI_COUNT){1'b0}}, {SGI_COUNT{1'b1}}};

  // R1: enables leave reset in their defined pattern
  a_r1_reset_enables: assert property (@(posedge clk)
    $fell(rst) |-> (en_vec == RST_EN && pend_vec == '0));

  // R2: a set-alias write only ever adds enable bits
  a_r2_set_only_adds: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == EN_SET_W0) |=>
      en_vec[DATA_W-1:0] == $past(en_vec[DATA_W-1:0] | bus_wdata));

  // R3: bits written 1 through the clear alias end up 0
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == EN_CLR_W0) |=>
      (en_vec[DATA_W-1:0] & $past(bus_wdata)) == '0);

  // R8: an asserted level-mode line always leaves its source pending
  a_r8_level_sets: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pend_vec & $past(~cfg_edge & (irq_in ^ pol_vec)))
              == $past(~cfg_edge & (irq_in ^ pol_vec))));

  // R11: request is the registered product of enable and pending
  a_r11_req_follows: assert property (@(posedge clk) disable iff (rst)
    !rst |=> req_vec == $past(en_vec & pend_vec));
endmodule

bind irq_pend_bank irq_pend_bank_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq_in(irq_in), .req_vec(req_vec), .en_vec(en_vec), .pend_vec(pend_vec),
  .cfg_edge(cfg_edge), .pol_vec(pol_vec)
);

// File: tb/irq_pend_bank_tb.sv
module irq_pend_bank_tb;
  localparam int NUM_SRC = 128;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam logic [3:0] EN_SET = 4'd0, EN_CLR = 4'd1, PD_SET = 4'd2,
                         PD_CLR = 4'd3, CFG = 4'd4, POL = 4'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, ack_valid = 1'b0;
  logic [ADDR_W-1:0]  bus_addr = '0;
  logic [DATA_W-1:0]  bus_wdata = '0;
  logic [DATA_W-1:0]  bus_rdata;
  logic [NUM_SRC-1:0] irq_in = '0;
  logic [6:0]         ack_id = '0;
  logic [NUM_SRC-1:0] req_vec;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irq_pend_bank u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .ack_valid(ack_valid), .ack_id(ack_id), .req_vec(req_vec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] rg, input logic [3:0] ix, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {rg, ix}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] rg, input logic [3:0] ix, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = {rg, ix};
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ack(input int id);
    @(negedge clk);
    ack_valid = 1'b1; ack_id = 7'(id);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 req_vec zero", {31'b0, |req_vec}, 32'h0);
    rd(EN_SET, 0, v); check("R1 enables w0", v, 32'h0000FFFF);
    rd(EN_SET, 1, v); check("R1 enables w1", v, 32'h0);
    rd(PD_SET, 0, v); check("R1 pending w0", v, 32'h0);
    rd(CFG, 0, v);    check("R5 sgi config", v, 32'hAAAAAAAA);
    rd(CFG, 1, v);    check("R1 private config level", v, 32'h0);
    rd(POL, 0, v);    check("R1 polarity", v, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr(EN_SET, 1, 32'h5);
    rd(EN_SET, 1, v); check("R2 set alias", v, 32'h5);
    wr(EN_SET, 1, 32'h0);
    rd(EN_SET, 1, v); check("R2 zero write no effect", v, 32'h5);
    wr(EN_CLR, 1, 32'h1);
    rd(EN_CLR, 1, v); check("R3 clear alias", v, 32'h4);
  endtask

  task automatic t_cfg;
    logic [31:0] v;
    wr(CFG, 0, 32'hFFFFFFFF);
    rd(CFG, 0, v); check("R5 sgi write ignored", v, 32'hAAAAAAAA);
    wr(CFG, 2, 32'hFFFFFFFF);
    rd(CFG, 2, v); check("R4 low bits read zero", v, 32'hAAAAAAAA);
    wr(CFG, 2, 32'h55550008);
    rd(CFG, 2, v); check("R4 only src33 edge", v, 32'h00000008);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(EN_SET, 1, 32'h2);
    @(negedge clk); irq_in[33] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7 R11 edge request", {31'b0, req_vec[33]}, 32'h1);
    ack(33);
    repeat (2) @(negedge clk);
    rd(PD_SET, 1, v); check("R10 R7 ack clears held edge", v & 32'h2, 32'h0);
    check("R11 request dropped", {31'b0, req_vec[33]}, 32'h0);
    irq_in[33] = 1'b0;
    @(negedge clk); irq_in[33] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7 new edge", {31'b0, req_vec[33]}, 32'h1);
    ack(33);
    irq_in[33] = 1'b0;
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(EN_SET, 2, 32'h1);
    @(negedge clk); irq_in[64] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 level request", {31'b0, req_vec[64]}, 32'h1);
    wr(PD_CLR, 2, 32'h1);
    rd(PD_SET, 2, v); check("R8 clear while high", v & 32'h1, 32'h1);
    ack(64);
    rd(PD_SET, 2, v); check("R10 set wins over ack", v & 32'h1, 32'h1);
    @(negedge clk); irq_in[64] = 1'b0;
    @(negedge clk);
    wr(PD_CLR, 2, 32'h1);
    rd(PD_CLR, 2, v); check("R9 clear alias", v & 32'h1, 32'h0);
  endtask

  task automatic t_pol;
    logic [31:0] v;
    wr(POL, 1, 32'h40);
    rd(POL, 1, v);    check("R6 polarity readback", v, 32'h40);
    rd(PD_SET, 2, v); check("R6 inverted idle line pends", v & 32'h40, 32'h40);
    rd(PD_SET, 0, v); check("R6 low sources untouched", v, 32'h0);
    rd(POL, 3, v);    check("R12 polarity index beyond range", v, 32'h0);
    wr(POL, 1, 32'h0);
    wr(PD_CLR, 2, 32'h40);
    rd(PD_SET, 2, v); check("R6 active-high again", v & 32'h40, 32'h0);
  endtask

  task automatic t_sw;
    logic [31:0] v;
    wr(PD_SET, 3, 32'h20);
    rd(PD_SET, 3, v); check("R9 set alias", v, 32'h20);
    rd(PD_CLR, 3, v); check("R9 clear alias read", v, 32'h20);
    check("R11 disabled not requested", {31'b0, req_vec[101]}, 32'h0);
    wr(EN_SET, 3, 32'h20);
    @(negedge clk);
    check("R11 enabled requested", {31'b0, req_vec[101]}, 32'h1);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(4'd7, 0, v);   check("R12 unmapped region", v, 32'h0);
    rd(EN_SET, 9, v); check("R12 index beyond range", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_enable;
    t_cfg;
    t_edge;
    t_level;
    t_pol;
    t_sw;
    t_unmapped;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule